// File: doc/BRIEF.md
# Burst Address Counter

This block generates the word address for one port of a dual-port memory array. It keeps a registered address and updates it on every rising clock edge. Three active-low controls decide the update: a clear, a load of an externally supplied address, or an increment by one. A host can therefore present one start address, then stream through consecutive words by holding the step control low. It does not have to drive a new address each cycle.

The controls follow a fixed priority. Clear wins over load, and load wins over increment. When no control is asserted the address is held. The counter covers the whole array, whose size is set by the address width parameter (13 bits for 8K words, 14 bits for 16K words). Incrementing past the top address returns the counter to zero, and that cycle is flagged with a one-cycle wrap pulse. The memory array itself is not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, and after it is released until the first update, `addr` is 0 and `wrap` is 0.
- R2: When `clear_n` is high and `strobe_n` is low at a rising edge, `addr` takes the value of `ext_addr` at that edge.
- R3: When `clear_n` is low at a rising edge, `addr` becomes 0, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R4: When `clear_n` and `strobe_n` are high and `step_n` is low at a rising edge, `addr` becomes its previous value plus one. This repeats on every consecutive edge for as long as `step_n` stays low.
- R5: `step_n` has no effect in any cycle where `strobe_n` or `clear_n` is low. A load with `step_n` low gives exactly `ext_addr`, not `ext_addr + 1`.
- R6: When `clear_n`, `strobe_n` and `step_n` are all high at a rising edge, `addr` keeps its value.
- R7: An increment from the all-ones address (2^ADDR_W − 1, 0x3FFF at the default width of 14) gives 0, and counting then carries on from 0.
- R8: `wrap` is 1 for exactly the one cycle after an increment from the all-ones address. It is 0 after every other update, including a clear or a load that sets `addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| ext_addr | input | ADDR_W | External start address, used on a load |
| strobe_n | input | 1 | Active-low load request |
| step_n | input | 1 | Active-low increment request |
| clear_n | input | 1 | Active-low counter clear, highest priority |
| addr | output | ADDR_W | Current word address to the array |
| wrap | output | 1 | One-cycle pulse after rollover from all-ones to zero |

## Verification
The bench aims at the priority corners. In these corners a design with the wrong order would show a loaded address plus one, or a cleared counter overwritten by a load. One run crosses the top of the address space with the step control held low, to catch a counter that saturates or skips zero. A wrap pulse that fires on any transition to zero is caught by clearing and loading to zero from the all-ones value. Hold cycles placed between bursts expose a counter that drifts when no control is asserted.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import bac_pkg::*;
(
  input  logic    strobe_n,
  input  logic    step_n,
  input  logic    clear_n,
  output bac_op_e op
);
  // Fixed priority: clear, then load, then step, else hold.
  always_comb begin
    if (!clear_n)       op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!step_n)   op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wrap_q, wrap_d;
  logic              upd_en;

  always_comb begin
    addr_d = addr_q;
    wrap_d = 1'b0;
    unique case (op)
      OP_CLEAR: addr_d = '0;
      OP_LOAD:  addr_d = ext_addr;
      OP_STEP: begin
        addr_d = addr_q + 1'b1;
        wrap_d = (addr_q == TOP_ADDR);
      end
      default:  addr_d = addr_q;
    endcase
  end

  assign upd_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= wrap_d;
  end

  assign addr = addr_q;
  assign wrap = wrap_q;

  // R4: a step adds exactly one (modulo the width)
  a_r4_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R7: stepping from the top address lands on zero
  a_r7_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && addr == TOP_ADDR) |=> (addr == '0));

  // R8: a wrap pulse always sits on address zero and never lasts two cycles
  a_r8_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (addr == '0));
  a_r8_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  bac_op_e op;

  bac_op_decode u_decode (
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clear_n  (clear_n),
    .op       (op)
  );

  bac_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (ext_addr),
    .addr     (addr),
    .wrap     (wrap)
  );

  // R3: clear wins over every other control
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (addr == '0 && !wrap));

  // R2, R5: a load takes the external address, step ignored
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !strobe_n) |=> (addr == $past(ext_addr) && !wrap));

  // R6: no control asserted keeps the address
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && step_n) |=> ($stable(addr) && !wrap));

  // R1: while reset is held the outputs are zero
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (addr == '0 && !wrap);
    end
  end
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 14;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n, step_n, clear_n;
  logic [AW-1:0] addr;
  logic          wrap;

  int    n_checks = 0;
  int    n_errors = 0;
  int    exp_addr;
  int    exp_wrap;
  string last_tag;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .strobe_n(strobe_n), .step_n(step_n), .clear_n(clear_n),
    .addr(addr), .wrap(wrap)
  );

  task automatic check_out(input string tag);
    n_checks++;
    if (int'(addr) != exp_addr || int'(wrap) != exp_wrap) begin
      n_errors++;
      $display("FAIL %s: addr=%0h wrap=%0d expected addr=%0h wrap=%0d",
               tag, addr, wrap, exp_addr, exp_wrap);
    end
  endtask

  // Apply controls at the falling edge; predict the state after the next rise.
  task automatic apply(input bit s_n, input bit t_n, input bit c_n,
                       input int ea, input string tag);
    strobe_n = s_n; step_n = t_n; clear_n = c_n; ext_addr = AW'(ea);
    exp_wrap = 0;
    if (!c_n)      exp_addr = 0;
    else if (!s_n) exp_addr = ea & TOP;
    else if (!t_n) begin
      if (exp_addr == TOP) exp_wrap = 1;
      exp_addr = (exp_addr + 1) & TOP;
    end
    last_tag = tag;
    @(negedge clk);
    check_out(last_tag);
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_n = 1'b0; step_n = 1'b0; clear_n = 1'b1;
    ext_addr = AW'(16'h1abc);
    exp_addr = 0; exp_wrap = 0;
    repeat (3) @(negedge clk);
    check_out("R1 during reset");
    strobe_n = 1'b1; step_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release");

    apply(0, 1, 1, 'h1234, "R2 load");
    for (int i = 0; i < 5; i++) apply(1, 0, 1, 0, "R4 burst step");
    apply(1, 1, 1, 'h0aaa, "R6 hold");
    apply(1, 1, 1, 'h0555, "R6 hold again");
    apply(0, 0, 1, 'h0200, "R5 load with step low");
    apply(0, 0, 0, 'h0300, "R3 clear beats load and step");
    apply(1, 0, 0, 0,      "R3 clear beats step");
    apply(0, 1, 1, TOP - 2, "R2 load near top");
    for (int i = 0; i < 4; i++) apply(1, 0, 1, 0, "R7 R8 step across top");
    apply(1, 0, 1, 0,      "R8 wrap one cycle");
    apply(0, 1, 1, TOP,    "R2 load top");
    apply(0, 0, 1, 0,      "R8 load zero from top no wrap");
    apply(0, 1, 1, TOP,    "R2 load top");
    apply(1, 0, 0, 0,      "R8 clear from top no wrap");
    apply(0, 1, 1, TOP,    "R2 load top");
    apply(1, 0, 1, 0,      "R7 rollover");
    apply(1, 1, 1, 0,      "R6 hold after wrap");

    for (int i = 0; i < 400; i++) begin
      bit s, t, c;
      s = ($urandom % 4) != 0;
      t = ($urandom % 3) == 0;
      c = ($urandom % 8) != 0;
      apply(s, t, c, int'($urandom % (TOP + 1)), "R2 R3 R4 R5 R6 mixed");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule